// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of words by a fixed number of clock cycles. The words are held in an inferred dual-ported RAM array, not in a long chain of flip-flops. The data stays where it was written. A write pointer and a read pointer sweep through the array, one entry per clock, and wrap back to entry zero after the last one. Every cycle, the incoming word is stored at the write pointer and the word at the read pointer is registered onto the output.

The read pointer resets to entry zero and the write pointer resets to the last entry. That offset of one entry fixes the delay. With `DEPTH = 2**ADDR_BITS` entries, a word sampled at one rising edge appears on `dout` just after the rising edge `DEPTH-1` cycles later.

The array holds unknown data after reset. A `valid` flag therefore stays low until the first word written after reset reaches the output. The asynchronous active-low reset passes through a two-stage release synchroniser before it reaches the rest of the block.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst_n` is low, `valid` and `dout` are 0. Driving `rst_n` low clears both at once, without waiting for a clock edge.
- R2: Count rising edges from the release of `rst_n`, starting at 1. Edges 1 and 2 complete the internal release. `valid` is 0 after every edge up to edge `DEPTH+1` and becomes 1 right after edge `DEPTH+2`.
- R3: While `valid` is 1, `dout` right after rising edge n equals the `din` sampled at rising edge n-(`DEPTH`-1).
- R4: Once `valid` is 1, it stays 1 until `rst_n` is next driven low.
- R5: The delay holds across pointer wraps. Over at least four full passes of the array, with all-zero, all-one, alternating (0x55/0xAA) and random data, every valid output matches the input sampled `DEPTH-1` edges earlier.
- R6: A reset in the middle of a stream discards the stored words. After the new release, `valid` again follows R2. Once `valid` is 1, every output is a word sampled after the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | WIDTH | Word sampled at every rising edge |
| dout | output | WIDTH | Registered word from the read pointer |
| valid | output | 1 | High once `dout` carries delayed input data |

## Verification
The hardest case to reach from the ports is a reset that arrives while the array is full of live data. Stale words then sit at exactly the addresses that the restarted read pointer visits first. The bench runs a full-length stream with a distinctive pattern and pulls `rst_n` low between clock edges. It checks that `valid` and `dout` clear before the next edge. It then streams fresh random data and requires that nothing from the old pattern ever appears while `valid` is high. The exact edge at which `valid` rises is checked edge by edge, both after the first reset and after the mid-stream one.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

  // Phase of the output: still filling the array, or carrying delayed data.
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_RUN  = 1'b1
  } rdl_phase_e;

endpackage

// File: rtl/rdl_reset_sync.sv
module rdl_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_nxt;

  always_comb begin
    stage_nxt = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_nxt;
    end
  end

  assign rst_int_n = stage_q[1];

endmodule

// File: rtl/rdl_ptr_pair.sv
module rdl_ptr_pair #(
  parameter int ADDR_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_int_n,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic [ADDR_BITS-1:0] wr_addr,
  output logic                 rd_last
);

  localparam logic [ADDR_BITS-1:0] LAST_ADDR = {ADDR_BITS{1'b1}};

  logic [ADDR_BITS-1:0] rd_q;
  logic [ADDR_BITS-1:0] wr_q;
  logic [ADDR_BITS-1:0] rd_nxt;
  logic [ADDR_BITS-1:0] wr_nxt;

  // Both pointers step by one every cycle and wrap naturally at 2**ADDR_BITS.
  always_comb begin
    rd_nxt = rd_q + 1'b1;
    wr_nxt = wr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q <= '0;
      wr_q <= LAST_ADDR;
    end else begin
      rd_q <= rd_nxt;
      wr_q <= wr_nxt;
    end
  end

  assign rd_addr = rd_q;
  assign wr_addr = wr_q;
  assign rd_last = (rd_q == LAST_ADDR);

  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_q == ADDR_BITS'(rd_q - 1'b1)); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> rd_q == ADDR_BITS'($past(rd_q) + 1'b1)); // R5

endmodule

// File: rtl/rdl_array.sv
module rdl_array #(
  parameter int WIDTH     = 8,
  parameter int ADDR_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_int_n,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [WIDTH-1:0]     wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic [WIDTH-1:0]     rd_data
);

  localparam int DEPTH = 1 << ADDR_BITS;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;
  logic [WIDTH-1:0] rd_nxt;

  // Storage carries no reset, like a real RAM macro.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Read takes the contents from before this edge's write.
  always_comb begin
    rd_nxt = rd_en ? mem[rd_addr] : rd_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_nxt;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/rdl_fill_track.sv
module rdl_fill_track
  import rdl_pkg::*;
(
  input  logic clk,
  input  logic rst_int_n,
  input  logic rd_last,
  output logic valid
);

  rdl_phase_e phase_q;
  rdl_phase_e phase_nxt;

  // The first written word reaches the output when the read pointer
  // has visited the last entry once.
  always_comb begin
    phase_nxt = phase_q;
    if (phase_q == PH_FILL && rd_last) begin
      phase_nxt = PH_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_FILL;
    end else begin
      phase_q <= phase_nxt;
    end
  end

  assign valid = (phase_q == PH_RUN);

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    valid |=> valid); // R4

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
  parameter int WIDTH     = 8,
  parameter int ADDR_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             valid
);

  logic                 rst_int_n;
  logic [ADDR_BITS-1:0] rd_addr;
  logic [ADDR_BITS-1:0] wr_addr;
  logic                 rd_last;
  logic                 wr_en;
  logic                 rd_en;

  rdl_reset_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  rdl_ptr_pair #(.ADDR_BITS(ADDR_BITS)) u_ptr (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .rd_last   (rd_last)
  );

  // Array ports are enabled only outside reset.
  assign wr_en = rst_int_n;
  assign rd_en = rst_int_n;

  rdl_array #(.WIDTH(WIDTH), .ADDR_BITS(ADDR_BITS)) u_mem (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (din),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (dout)
  );

  rdl_fill_track u_fill (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .rd_last   (rd_last),
    .valid     (valid)
  );

  AST_VALID_FIRST: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(valid) |-> rd_addr == '0); // R2

endmodule

// File: tb/ram_delay_line_test.sv
module ram_delay_line_test;

  localparam int PERIOD    = 10;
  localparam int WIDTH     = 8;
  localparam int ADDR_BITS = 4;
  localparam int DEPTH     = 1 << ADDR_BITS;
  localparam int DELAY     = DEPTH - 1;

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] din;
  logic [WIDTH-1:0] dout;
  logic             valid;

  int checks;
  int errors;
  int edges;
  logic [WIDTH-1:0] hist [$];

  ram_delay_line #(.WIDTH(WIDTH), .ADDR_BITS(ADDR_BITS)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .dout  (dout),
    .valid (valid)
  );

  initial begin
    clk = 1'b0;
    forever #(PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [WIDTH-1:0] act,
                     input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d actual %h expected %h", req, edges, act, exp);
    end
  endtask

  // Drive one word, let one rising edge pass, check at the falling edge.
  task automatic step(input logic [WIDTH-1:0] d, input string req);
    din = d;
    @(posedge clk);
    hist.push_back(d);
    edges++;
    @(negedge clk);
    if (edges >= DEPTH + 2) begin
      chk({req, " valid"}, {7'd0, valid}, 8'd1);
      chk(req, dout, hist[edges - 1 - DELAY]);
    end else begin
      chk("R2 valid low while filling", {7'd0, valid}, 8'd0);
    end
  endtask

  // Reset asserted between edges; outputs must clear before the next edge.
  task automatic t_reset();
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1 valid async clear", {7'd0, valid}, 8'd0);
    chk("R1 dout async clear", dout, '0);
    repeat (3) @(negedge clk);
    chk("R1 valid held in reset", {7'd0, valid}, 8'd0);
    chk("R1 dout held in reset", dout, '0);
    rst_n = 1'b1;
    hist.delete();
    edges = 0;
  endtask

  task automatic t_pattern(input int kind, input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      logic [WIDTH-1:0] d;
      case (kind)
        0:       d = '0;
        1:       d = '1;
        2:       d = (i % 2 == 0) ? 8'h55 : 8'hAA;
        default: d = WIDTH'($urandom);
      endcase
      step(d, req);
    end
  endtask

  // Fill with a marker value, reset mid-stream, then require no marker.
  task automatic t_midreset();
    t_pattern(1, 2 * DEPTH, "R6 prefill");
    t_reset();
    for (int i = 0; i < 3 * DEPTH; i++) begin
      logic [WIDTH-1:0] d;
      d = WIDTH'($urandom_range(0, 254));
      step(d, "R6 fresh data after reset");
      if (valid === 1'b1) begin
        chk("R6 no stale word", {7'd0, dout == 8'hFF}, 8'd0);
      end
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    edges  = 0;
    din    = '0;
    rst_n  = 1'b0;
    #1;
    chk("R1 valid at reset", {7'd0, valid}, 8'd0);
    chk("R1 dout at reset", dout, '0);
    t_reset();
    t_pattern(3, DEPTH + 4, "R3 first pass random");
    t_pattern(0, DEPTH, "R5 zeros");
    t_pattern(1, DEPTH, "R5 ones");
    t_pattern(2, DEPTH, "R5 alternating");
    t_pattern(3, 4 * DEPTH, "R5 random wraps");
    t_pattern(3, 2 * DEPTH, "R4 valid stays high");
    t_midreset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule